// File: doc/BRIEF.md
# Two-Wire Target with 16-bit Register Words

This block is a target (slave) on a two-wire serial bus of the I2C kind. It lets an external bus master read and write a bank of 16-bit registers that are reached through 16-bit register addresses. SCL and SDA are oversampled by the system clock through a synchronizer. Start, repeated start and stop are detected from the synchronized lines. The block answers only to its own 7-bit device ID and drives SDA as an open-drain output.

A write frame carries the device ID with the direction bit clear, two address bytes (upper byte first) and then any number of data words. Each word is sent as the upper byte, then the lower byte. A read from a chosen address first sends the address in a write frame. A repeated start and the device ID with the direction bit set follow. The block then returns words upper byte first, for as long as the master acknowledges. On the register side there is a plain synchronous port: address, write data, a one-cycle write strobe, a one-cycle read strobe, and read data that is valid on the clock after the read strobe. After each word the address either advances by one or stays where it is, as the `autoinc_en` input selects.

Top module: `i2c_word_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and neither `reg_wr` nor `reg_rd` is asserted.
- R2: The first byte after a start is matched against the device ID. Its bits 7..1 must equal `DEV_ID` (default 7'h1A), and bit 0 is the direction (0 = write, 1 = read). On a match the target pulls SDA low in the ninth clock. On a mismatch it never pulls SDA low and produces no strobe until the next start.
- R3: In a write frame the target acknowledges the upper address byte, the lower address byte and every data byte. After the lower byte of each word it issues exactly one `reg_wr` pulse, with `reg_addr` equal to the 16-bit address and `reg_wdata` equal to {upper byte, lower byte}.
- R4: After each word, written or read, `reg_addr` advances by one if `autoinc_en` is 1. If `autoinc_en` is 0, it keeps the same value, so later words of the frame access the same address.
- R5: After a repeated start with the device ID and direction bit 1, the target drives the word at the current address onto SDA. It sends the upper byte first, and each byte MSB first.
- R6: A master acknowledge after the lower byte makes the target fetch and send the next word. A not-acknowledge makes it release SDA and ignore the bus until the next start or stop.
- R7: A start or stop that arrives in the middle of a byte abandons the frame with no register write. A write frame that ends after only the upper data byte of a word does not write that word.
- R8: `sda_oe` is 1 only during a target acknowledge bit or a 0-valued read data bit, and it only goes high while SCL is low.
- R9: `reg_wr` and `reg_rd` are single-cycle pulses. `reg_rdata` is taken on the clock after `reg_rd`. A read frame of N words issues exactly N read strobes, with no fetch after the final, not-acknowledged word.
- R10: `reg_wr` and `reg_rd` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| autoinc_en | input | 1 | 1 advances the register address after each word |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 16 | Register write data |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 16 | Register read data, valid the cycle after `reg_rd` |

## Verification
The bench sends a frame that stops after the upper data byte. A design that writes on every data byte would commit a half-formed word there. It also drops a stop and a start into the middle of the lower data byte: a design that does not clear its byte position would write garbage or lose sync on the next frame. Burst reads and burst writes are run with the address increment on and off. This exposes a design that increments per byte, before the fetch, or never. Read strobes are counted against the not-acknowledged last word, which catches a design that prefetches past the end of the burst. Finally, a foreign device ID is followed by a full write frame, which would show any target that acknowledges or writes while it should be ignoring the bus.

// File: rtl/i2c_wt_pkg.sv
package i2c_wt_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int BIT_CW = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    PH_IDLE, PH_RXBIT, PH_RXEND, PH_RXACK, PH_TXBIT, PH_TXACK, PH_TXNEXT
  } phase_t;

  typedef enum logic [2:0] {
    BY_DEV, BY_AHI, BY_ALO, BY_DHI, BY_DLO, BY_RD
  } role_t;
endpackage

// File: rtl/i2c_wt_rstsync.sv
module i2c_wt_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_wt_sync.sv
module i2c_wt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, cur, prev_q;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[STAGES-2:0], raw[g]};
    end
    assign cur[g] = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= cur;
  end

  assign sda_s     = cur[1];
  assign scl_rise  =  cur[0] & ~prev_q[0];
  assign scl_fall  = ~cur[0] &  prev_q[0];
  assign start_det =  cur[0] &  prev_q[0] &  prev_q[1] & ~cur[1];
  assign stop_det  =  cur[0] &  prev_q[0] & ~prev_q[1] &  cur[1];
endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target
  import i2c_wt_pkg::*;
#(
  parameter logic [6:0] DEV_ID      = 7'h1A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              autoinc_en,
  output logic [WORD_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [WORD_W-1:0] reg_rdata
);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  logic rst_n_s;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_wt_rstsync #(.STAGES(2)) rsync_i (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_n_s)
  );

  i2c_wt_sync #(.STAGES(SYNC_STAGES)) lsync_i (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  phase_t             phase_q, phase_d;
  role_t              role_q, role_d;
  logic [BIT_CW-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0]  rx_sr_q, rx_sr_d;
  logic [BYTE_W-2:0]  tx_sr_q, tx_sr_d;
  logic [BYTE_W-1:0]  dhi_q, dhi_d;
  logic [WORD_W-1:0]  addr_q, addr_d, wdata_q, wdata_d, word_q, word_d;
  logic               wr_q, wr_d, rd_q, rd_d, cap_q, cap_d;
  logic               oe_q, oe_d, tx_lo_q, tx_lo_d;
  logic [BYTE_W-1:0]  rx_byte, tx_byte;

  assign rx_byte = {rx_sr_q, sda_s};
  assign tx_byte = tx_lo_q ? word_q[BYTE_W-1:0] : word_q[WORD_W-1:BYTE_W];

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    role_d  = role_q;
    cnt_d   = cnt_q;
    rx_sr_d = rx_sr_q;
    tx_sr_d = tx_sr_q;
    dhi_d   = dhi_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    word_d  = word_q;
    oe_d    = oe_q;
    tx_lo_d = tx_lo_q;
    wr_d    = 1'b0;
    rd_d    = 1'b0;
    cap_d   = rd_q;
    if (cap_q) word_d = reg_rdata;
    if ((wr_q || rd_q) && autoinc_en) addr_d = addr_q + 1'b1;

    if (start_det) begin
      phase_d = PH_RXBIT;
      role_d  = BY_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      phase_d = PH_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (phase_q)
        PH_RXBIT: if (scl_rise) begin
          rx_sr_d = rx_byte[BYTE_W-2:0];
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            phase_d = PH_RXEND;
            case (role_q)
              BY_DEV: begin
                if (rx_byte[BYTE_W-1:1] != DEV_ID) begin
                  phase_d = PH_IDLE;
                end else if (rx_byte[0]) begin
                  role_d = BY_RD;
                  rd_d   = 1'b1;
                end else begin
                  role_d = BY_AHI;
                end
              end
              BY_AHI: begin
                addr_d[WORD_W-1:BYTE_W] = rx_byte;
                role_d = BY_ALO;
              end
              BY_ALO: begin
                addr_d[BYTE_W-1:0] = rx_byte;
                role_d = BY_DHI;
              end
              BY_DHI: begin
                dhi_d  = rx_byte;
                role_d = BY_DLO;
              end
              BY_DLO: begin
                wdata_d = {dhi_q, rx_byte};
                wr_d    = 1'b1;
                role_d  = BY_DHI;
              end
              default: phase_d = PH_IDLE;
            endcase
          end
        end
        PH_RXEND: if (scl_fall) begin
          oe_d    = 1'b1;
          phase_d = PH_RXACK;
        end
        PH_RXACK: if (scl_fall) begin
          cnt_d = '0;
          if (role_q == BY_RD) begin
            phase_d = PH_TXBIT;
            tx_sr_d = word_q[WORD_W-2:BYTE_W];
            oe_d    = ~word_q[WORD_W-1];
            tx_lo_d = 1'b1;
          end else begin
            phase_d = PH_RXBIT;
            oe_d    = 1'b0;
          end
        end
        PH_TXBIT: if (scl_fall) begin
          if (cnt_q == LAST_BIT) begin
            phase_d = PH_TXACK;
            oe_d    = 1'b0;
          end else begin
            cnt_d   = cnt_q + 1'b1;
            oe_d    = ~tx_sr_q[BYTE_W-2];
            tx_sr_d = {tx_sr_q[BYTE_W-3:0], 1'b0};
          end
        end
        PH_TXACK: if (scl_rise) begin
          if (sda_s) begin
            phase_d = PH_IDLE;
          end else begin
            phase_d = PH_TXNEXT;
            if (!tx_lo_q) rd_d = 1'b1;
          end
        end
        PH_TXNEXT: if (scl_fall) begin
          phase_d = PH_TXBIT;
          cnt_d   = '0;
          tx_sr_d = tx_byte[BYTE_W-2:0];
          oe_d    = ~tx_byte[BYTE_W-1];
          tx_lo_d = ~tx_lo_q;
        end
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      phase_q <= PH_IDLE;
      role_q  <= BY_DEV;
      cnt_q   <= '0;
      rx_sr_q <= '0;
      tx_sr_q <= '0;
      dhi_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      word_q  <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      cap_q   <= 1'b0;
      oe_q    <= 1'b0;
      tx_lo_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      role_q  <= role_d;
      cnt_q   <= cnt_d;
      rx_sr_q <= rx_sr_d;
      tx_sr_q <= tx_sr_d;
      dhi_q   <= dhi_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      word_q  <= word_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      cap_q   <= cap_d;
      oe_q    <= oe_d;
      tx_lo_q <= tx_lo_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_wr    = wr_q;
  assign reg_rd    = rd_q;
endmodule

// File: rtl/i2c_wt_checker.sv
module i2c_wt_checker
  import i2c_wt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              autoinc_en,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [WORD_W-1:0] reg_addr,
  input phase_t            phase
);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) && autoinc_en |=> reg_addr == $past(reg_addr) + 16'd1);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) && !autoinc_en |=> $stable(reg_addr));

  assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe);
endmodule

bind i2c_word_target i2c_wt_checker chk_i (
  .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_oe(sda_oe),
  .autoinc_en(autoinc_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .phase(phase_q)
);

// File: tb/i2c_word_target_tb_top.sv
`timescale 1ns/1ps
module i2c_word_target_tb_top;
  localparam int Q = 8;
  localparam logic [7:0] ID_W = 8'h34;
  localparam logic [7:0] ID_R = 8'h35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1, autoinc = 1'b1;
  logic sda_oe, reg_wr, reg_rd, sda_line;
  logic [15:0] reg_addr, reg_wdata, reg_rdata;

  int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0, oe_bad = 0;
  logic [15:0] last_waddr;
  logic [15:0] mem [256];
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = msda & ~sda_oe;

  i2c_word_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .autoinc_en(autoinc), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] init_val(int a);
    return 16'(a * 257) ^ 16'h5A3C;
  endfunction

  // Register bank model with a registered read
  always @(posedge clk) begin
    if (reg_wr) begin
      mem[reg_addr[7:0]] <= reg_wdata;
      last_waddr <= reg_addr;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_rd) begin
      reg_rdata <= mem[reg_addr[7:0]];
      rd_cnt <= rd_cnt + 1;
    end
    if (rst_n && scl && sda_oe && !oe_prev) oe_bad <= oe_bad + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; qw(); scl = 1'b1; qw(); msda = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    msda = 1'b0; qw(); scl = 1'b1; qw(); msda = 1'b1; qw();
  endtask

  task automatic send_bit(logic b);
    msda = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    msda = 1'b1; qw(); scl = 1'b1; qw(); b = sda_line; qw(); scl = 1'b0; qw();
  endtask

  task automatic send_byte(logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~mack);
  endtask

  task automatic send_addr(logic [15:0] a, string req);
    logic ack;
    send_byte(ID_W, ack);     chk({req, " id ack"}, ack, 1);
    send_byte(a[15:8], ack);  chk({req, " addr hi ack"}, ack, 1);
    send_byte(a[7:0], ack);   chk({req, " addr lo ack"}, ack, 1);
  endtask

  task automatic write_frame(logic [15:0] a, logic [15:0] w [3], int n, string req);
    logic ack;
    bus_start();
    send_addr(a, req);
    for (int k = 0; k < n; k++) begin
      send_byte(w[k][15:8], ack); chk({req, " data hi ack"}, ack, 1);
      send_byte(w[k][7:0], ack);  chk({req, " data lo ack"}, ack, 1);
    end
    bus_stop();
  endtask

  task automatic read_frame(logic [15:0] a, int n, output logic [15:0] r [3]);
    logic ack;
    logic [7:0] hi, lo;
    bus_start();
    send_addr(a, "R5");
    bus_start();
    send_byte(ID_R, ack); chk("R5 read id ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(1'b1, hi);
      recv_byte(k != n - 1, lo);
      r[k] = {hi, lo};
    end
    qw();
    chk("R6 sda released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 sda_oe at reset", sda_oe, 0);
    chk("R1 reg_wr at reset", reg_wr, 0);
    chk("R1 reg_rd at reset", reg_rd, 0);
  endtask

  task automatic t_write_single();
    logic [15:0] w [3] = '{16'hBEEF, 16'h0, 16'h0};
    int c0 = wr_cnt;
    write_frame(16'hA512, w, 1, "R3");
    chk("R3 one write", wr_cnt - c0, 1);
    chk("R3 full 16-bit address", last_waddr, 16'hA512);
    chk("R3 data word", mem[8'h12], 16'hBEEF);
  endtask

  task automatic t_burst_write();
    logic [15:0] w [3] = '{16'h1111, 16'h2222, 16'h3333};
    int c0;
    autoinc = 1'b1;
    write_frame(16'h0020, w, 3, "R4");
    chk("R4 inc word0", mem[8'h20], 16'h1111);
    chk("R4 inc word1", mem[8'h21], 16'h2222);
    chk("R4 inc word2", mem[8'h22], 16'h3333);
    chk("R4 inc last addr", last_waddr, 16'h0022);
    autoinc = 1'b0;
    c0 = wr_cnt;
    w = '{16'h4444, 16'h5555, 16'h0};
    write_frame(16'h0030, w, 2, "R4");
    chk("R4 hold two writes", wr_cnt - c0, 2);
    chk("R4 hold same addr", mem[8'h30], 16'h5555);
    chk("R4 hold neighbour untouched", mem[8'h31], init_val(8'h31));
    autoinc = 1'b1;
  endtask

  task automatic t_read();
    logic [15:0] r [3];
    int c0 = rd_cnt;
    read_frame(16'h0050, 1, r);
    chk("R5 single read word", r[0], init_val(8'h50));
    chk("R9 one read strobe", rd_cnt - c0, 1);
    c0 = rd_cnt;
    read_frame(16'h0060, 3, r);
    chk("R6 burst word0", r[0], init_val(8'h60));
    chk("R6 burst word1", r[1], init_val(8'h61));
    chk("R6 burst word2", r[2], init_val(8'h62));
    chk("R9 three read strobes", rd_cnt - c0, 3);
    autoinc = 1'b0;
    read_frame(16'h0070, 2, r);
    chk("R4 read hold word0", r[0], init_val(8'h70));
    chk("R4 read hold word1", r[1], init_val(8'h70));
    autoinc = 1'b1;
  endtask

  task automatic t_bad_id();
    logic ack;
    int c0 = wr_cnt;
    bus_start();
    send_byte(8'h36, ack); chk("R2 foreign id no ack", ack, 0);
    send_byte(8'h00, ack); chk("R2 ignored addr hi", ack, 0);
    send_byte(8'h40, ack); chk("R2 ignored addr lo", ack, 0);
    send_byte(8'h12, ack); chk("R2 ignored data hi", ack, 0);
    send_byte(8'h34, ack); chk("R2 ignored data lo", ack, 0);
    bus_stop();
    chk("R2 no write after foreign id", wr_cnt - c0, 0);
    chk("R2 target untouched", mem[8'h40], init_val(8'h40));
  endtask

  task automatic t_abort();
    logic ack;
    logic [15:0] w [3] = '{16'hC0DE, 16'h0, 16'h0};
    int c0 = wr_cnt;
    bus_start();
    send_addr(16'h0041, "R7");
    send_byte(8'h77, ack);
    bus_stop();
    chk("R7 half word no write", wr_cnt - c0, 0);
    bus_start();
    send_addr(16'h0042, "R7");
    send_byte(8'h77, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    chk("R7 stop mid byte no write", wr_cnt - c0, 0);
    bus_start();
    send_addr(16'h0043, "R7");
    send_byte(8'h77, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    write_frame(16'h0044, w, 1, "R7");
    chk("R7 restart then one write", wr_cnt - c0, 1);
    chk("R7 aborted addr untouched", mem[8'h43], init_val(8'h43));
    chk("R7 new frame written", mem[8'h44], 16'hC0DE);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    reg_rdata = '0;
    last_waddr = '0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_write_single();
    t_burst_write();
    t_read();
    t_bad_id();
    t_abort();
    chk("R8 sda_oe never rose with scl high", oe_bad, 0);
    chk("R8 sda released at end", sda_oe, 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule